// File: doc/BRIEF.md
# In-Order Retirement Queue with Latest-Producer Lookup

This block is a circular queue that holds every issued instruction from issue until it retires. Entries are allocated at the tail in program order. Each entry records its destination register, its PC, the result value, and flags for ready, exception and "latest writer of this register". Results arrive on a broadcast result bus that carries a tag. The entry with the matching tag captures the value and becomes ready. The queue then retires entries strictly from the head, one per cycle, and each retirement becomes a register-file write.

Two lookup ports let the issue stage resolve source operands. Each port takes a register address. It reports whether an in-flight producer exists, the producer's tag, whether its result has arrived, and the value. Only the most recently issued producer of an address can match.

When the head entry completes with an exception, the whole queue is discarded without writing anything back. For one cycle the block raises an exception pulse and presents the PC of the faulting instruction.

Top module: `rob_core`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0), `rf_we`=0, `exc_flag`=0, and neither lookup port reports a hit.
- R2: An issue is accepted on a rising edge when `iss_valid`=1 and `full`=0. The tag given to that instruction is shown on `iss_tag` before the edge. The tag equals the slot index plus one, so tags run 1..DEPTH and return to 1 after DEPTH, and tag 0 never names an entry.
- R3: After DEPTH outstanding issues `full`=1. An issue attempted while full is ignored: `iss_tag` keeps its value and no extra entry is ever retired.
- R4: When `bus_valid`=1 and `bus_tag` matches a valid entry whose result is still pending, that entry stores `bus_value` and `bus_exc` at the edge. From the next cycle a lookup that hits it reports `rd_ready`=1 and that value.
- R5: When the head entry is valid, ready and not excepting, it retires. In the following cycle `rf_we`=1 for exactly one cycle, with `rf_addr` set to its destination and `rf_data` set to its result. Retirement follows issue order, so a younger ready entry waits behind an older pending one.
- R6: An empty queue never retires: `rf_we` stays 0 in the cycle after any cycle with `empty`=1.
- R7: Issuing to an address removes the "latest" mark from every older in-flight entry with the same address. A lookup of that address then returns only the youngest producer's tag.
- R8: The two lookup ports are independent and may look up different addresses in the same cycle.
- R9: When the head entry is ready and marked as an exception, nothing is written back. In the next cycle `exc_flag`=1 for one cycle, `exc_pc` holds that entry's PC, and the queue is empty with no lookup hits.
- R10: A lookup of an address with no in-flight producer, for example after its only producer retired, reports `rd_hit`=0.
- R11: An issue presented in the cycle in which the queue is being flushed is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_dest | input | AW | Destination register of the issued instruction |
| iss_pc | input | PCW | PC of the issued instruction |
| iss_tag | output | TW | Tag the next accepted issue will receive |
| full | output | 1 | All DEPTH slots occupied |
| empty | output | 1 | No slot occupied |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | TW | Tag of the producing entry |
| bus_value | input | DW | Result value |
| bus_exc | input | 1 | Result is an exception |
| rd_addr_a | input | AW | Lookup port A register address |
| rd_hit_a | output | 1 | Port A found an in-flight latest producer |
| rd_tag_a | output | TW | Port A producer tag |
| rd_ready_a | output | 1 | Port A producer result present |
| rd_value_a | output | DW | Port A producer value |
| rd_addr_b | input | AW | Lookup port B register address |
| rd_hit_b | output | 1 | Port B found an in-flight latest producer |
| rd_tag_b | output | TW | Port B producer tag |
| rd_ready_b | output | 1 | Port B producer result present |
| rd_value_b | output | DW | Port B producer value |
| rf_we | output | 1 | Register-file write strobe (one cycle per retirement) |
| rf_addr | output | AW | Register-file write address |
| rf_data | output | DW | Register-file write data |
| exc_flag | output | 1 | One-cycle exception flush pulse |
| exc_pc | output | PCW | PC of the faulting instruction |

## Verification
The bench uses the default parameters: DEPTH=16, 5-bit addresses and 32-bit data and PC. With a depth of 16, a single fill from a non-zero tail drives the tail across the wrap point and makes tags 16 and 1 appear back to back. The same fill reaches the full state, so a blocked issue can be tried. Sixteen retirements, one flush and a second flush then bring the head pointer around the ring in a few hundred cycles. The 32 register addresses let the fill give each entry its own destination, which makes every scoreboard item unambiguous.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Tag carried by slot idx; zero is kept free to mean "no producer".
  function automatic int tag_of(input int idx);
    return idx + 1;
  endfunction

  // Ring pointer step with wrap at depth.
  function automatic int ptr_next(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/rob_ring.sv
module rob_ring #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic          full,
  output logic          empty
);
  logic [IW:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= IW'(rob_pkg::ptr_next(int'(tail), DEPTH));
      if (pop)  head <= IW'(rob_pkg::ptr_next(int'(head), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full  = (count == (IW+1)'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/rob_slot.sv
module rob_slot #(
  parameter int IDX = 0,
  parameter int AW  = 5,
  parameter int DW  = 32,
  parameter int PCW = 32,
  parameter int TW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           load,
  input  logic           any_load,
  input  logic [AW-1:0]  ld_dest,
  input  logic [PCW-1:0] ld_pc,
  input  logic           retire,
  input  logic           bus_valid,
  input  logic [TW-1:0]  bus_tag,
  input  logic [DW-1:0]  bus_value,
  input  logic           bus_exc,
  output logic           o_valid,
  output logic           o_ready,
  output logic           o_exc,
  output logic           o_newest,
  output logic [AW-1:0]  o_dest,
  output logic [DW-1:0]  o_value,
  output logic [PCW-1:0] o_pc
);
  localparam logic [TW-1:0] MY_TAG = TW'(rob_pkg::tag_of(IDX));

  logic hit_bus, shadowed;
  assign hit_bus  = o_valid && !o_ready && bus_valid && (bus_tag == MY_TAG);
  assign shadowed = any_load && o_valid && (ld_dest == o_dest);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid  <= 1'b0;
      o_ready  <= 1'b0;
      o_exc    <= 1'b0;
      o_newest <= 1'b0;
      o_dest   <= '0;
      o_value  <= '0;
      o_pc     <= '0;
    end else if (flush) begin
      o_valid  <= 1'b0;
      o_ready  <= 1'b0;
      o_exc    <= 1'b0;
      o_newest <= 1'b0;
    end else if (load) begin
      o_valid  <= 1'b1;
      o_ready  <= 1'b0;
      o_exc    <= 1'b0;
      o_newest <= 1'b1;
      o_dest   <= ld_dest;
      o_pc     <= ld_pc;
    end else begin
      if (shadowed) o_newest <= 1'b0;
      if (retire) begin
        o_valid  <= 1'b0;
        o_ready  <= 1'b0;
        o_newest <= 1'b0;
      end else if (hit_bus) begin
        o_ready <= 1'b1;
        o_value <= bus_value;
        o_exc   <= bus_exc;
      end
    end
  end
endmodule

// File: rtl/rob_find.sv
module rob_find #(
  parameter int DEPTH = 16,
  parameter int AW    = 5,
  parameter int DW    = 32,
  parameter int TW    = 5
) (
  input  logic [DEPTH-1:0]         valid,
  input  logic [DEPTH-1:0]         newest,
  input  logic [DEPTH-1:0]         ready,
  input  logic [DEPTH-1:0][AW-1:0] dests,
  input  logic [DEPTH-1:0][DW-1:0] values,
  input  logic [AW-1:0]            q_addr,
  output logic                     hit,
  output logic [TW-1:0]            tag,
  output logic                     rdy,
  output logic [DW-1:0]            val
);
  always_comb begin
    hit = 1'b0;
    tag = '0;
    rdy = 1'b0;
    val = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid[i] && newest[i] && dests[i] == q_addr) begin
        hit = 1'b1;
        tag = TW'(rob_pkg::tag_of(i));
        rdy = ready[i];
        val = values[i];
      end
    end
  end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH = 16,
  parameter int AW    = 5,
  parameter int DW    = 32,
  parameter int PCW   = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int TW   = IW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_valid,
  input  logic [AW-1:0]  iss_dest,
  input  logic [PCW-1:0] iss_pc,
  output logic [TW-1:0]  iss_tag,
  output logic           full,
  output logic           empty,
  input  logic           bus_valid,
  input  logic [TW-1:0]  bus_tag,
  input  logic [DW-1:0]  bus_value,
  input  logic           bus_exc,
  input  logic [AW-1:0]  rd_addr_a,
  output logic           rd_hit_a,
  output logic [TW-1:0]  rd_tag_a,
  output logic           rd_ready_a,
  output logic [DW-1:0]  rd_value_a,
  input  logic [AW-1:0]  rd_addr_b,
  output logic           rd_hit_b,
  output logic [TW-1:0]  rd_tag_b,
  output logic           rd_ready_b,
  output logic [DW-1:0]  rd_value_b,
  output logic           rf_we,
  output logic [AW-1:0]  rf_addr,
  output logic [DW-1:0]  rf_data,
  output logic           exc_flag,
  output logic [PCW-1:0] exc_pc
);
  logic [IW-1:0] head, tail;
  logic [DEPTH-1:0] s_valid, s_ready, s_exc, s_newest;
  logic [DEPTH-1:0][AW-1:0]  s_dest;
  logic [DEPTH-1:0][DW-1:0]  s_value;
  logic [DEPTH-1:0][PCW-1:0] s_pc;

  // Named internal events, observed by the bound checker.
  logic issue_go, commit_go, flush_go;
  logic h_valid, h_ready, h_exc;

  assign h_valid   = s_valid[head];
  assign h_ready   = s_ready[head];
  assign h_exc     = s_exc[head];
  assign flush_go  = !empty && h_valid && h_ready && h_exc;
  assign commit_go = !empty && h_valid && h_ready && !h_exc;
  assign issue_go  = iss_valid && !full && !flush_go;
  assign iss_tag   = TW'(rob_pkg::tag_of(int'(tail)));

  rob_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(issue_go), .pop(commit_go),
    .flush(flush_go), .head(head), .tail(tail), .full(full), .empty(empty)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rob_slot #(.IDX(g), .AW(AW), .DW(DW), .PCW(PCW), .TW(TW)) u_slot (
      .clk(clk), .rst_n(rst_n), .flush(flush_go),
      .load(issue_go && tail == IW'(g)), .any_load(issue_go),
      .ld_dest(iss_dest), .ld_pc(iss_pc),
      .retire(commit_go && head == IW'(g)),
      .bus_valid(bus_valid), .bus_tag(bus_tag),
      .bus_value(bus_value), .bus_exc(bus_exc),
      .o_valid(s_valid[g]), .o_ready(s_ready[g]), .o_exc(s_exc[g]),
      .o_newest(s_newest[g]), .o_dest(s_dest[g]),
      .o_value(s_value[g]), .o_pc(s_pc[g])
    );
  end

  rob_find #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) u_find_a (
    .valid(s_valid), .newest(s_newest), .ready(s_ready), .dests(s_dest),
    .values(s_value), .q_addr(rd_addr_a), .hit(rd_hit_a), .tag(rd_tag_a),
    .rdy(rd_ready_a), .val(rd_value_a)
  );

  rob_find #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) u_find_b (
    .valid(s_valid), .newest(s_newest), .ready(s_ready), .dests(s_dest),
    .values(s_value), .q_addr(rd_addr_b), .hit(rd_hit_b), .tag(rd_tag_b),
    .rdy(rd_ready_b), .val(rd_value_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_we    <= 1'b0;
      rf_addr  <= '0;
      rf_data  <= '0;
      exc_flag <= 1'b0;
      exc_pc   <= '0;
    end else begin
      rf_we    <= commit_go;
      exc_flag <= flush_go;
      if (commit_go) begin
        rf_addr <= s_dest[head];
        rf_data <= s_value[head];
      end
      if (flush_go) exc_pc <= s_pc[head];
    end
  end
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     empty,
  input logic                     full,
  input logic                     rf_we,
  input logic                     exc_flag,
  input logic                     issue_go,
  input logic                     commit_go,
  input logic                     flush_go,
  input logic [AW-1:0]            rd_addr_a,
  input logic [DEPTH-1:0]         s_valid,
  input logic [DEPTH-1:0]         s_newest,
  input logic [DEPTH-1:0][AW-1:0] s_dest
);
  logic [DEPTH-1:0] match_a;
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      match_a[i] = s_valid[i] && s_newest[i] && (s_dest[i] == rd_addr_a);
  end

  a_r6_empty_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> !rf_we);

  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !commit_go && !flush_go) |=> full);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flag |-> (empty && !rf_we));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flag |=> !exc_flag);

  a_r2_issue_occupies: assert property (@(posedge clk) disable iff (!rst_n)
    issue_go |=> !empty);

  a_r7_one_latest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_a));
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .empty(empty), .full(full), .rf_we(rf_we),
  .exc_flag(exc_flag), .issue_go(issue_go), .commit_go(commit_go),
  .flush_go(flush_go), .rd_addr_a(rd_addr_a), .s_valid(s_valid),
  .s_newest(s_newest), .s_dest(s_dest)
);

// File: tb/tb_rob_core.sv
`timescale 1ns/1ps
module tb_rob_core;
  localparam int DEPTH = 16;
  localparam int AW = 5, DW = 32, PCW = 32, TW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid = 1'b0, bus_valid = 1'b0, bus_exc = 1'b0;
  logic [AW-1:0] iss_dest = '0, rd_addr_a = '0, rd_addr_b = '0;
  logic [PCW-1:0] iss_pc = '0;
  logic [TW-1:0] bus_tag = '0;
  logic [DW-1:0] bus_value = '0;
  logic [TW-1:0] iss_tag, rd_tag_a, rd_tag_b;
  logic full, empty, rd_hit_a, rd_ready_a, rd_hit_b, rd_ready_b;
  logic [DW-1:0] rd_value_a, rd_value_b, rf_data;
  logic rf_we, exc_flag;
  logic [AW-1:0] rf_addr;
  logic [PCW-1:0] exc_pc;

  always #2.5 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PCW(PCW)) dut (.*);

  int nchk = 0, nerr = 0;
  logic [AW+DW-1:0] exp_q[$];
  logic [TW-1:0] tg;
  int btail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_commit(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic issue_one(input logic [AW-1:0] d, input logic [PCW-1:0] p, output logic [TW-1:0] t);
    iss_valid = 1'b1; iss_dest = d; iss_pc = p;
    #0.5 t = iss_tag;
    @(posedge clk); #0.5;
    iss_valid = 1'b0;
  endtask

  task automatic bus_put(input logic [TW-1:0] t, input logic [DW-1:0] v, input logic e);
    bus_valid = 1'b1; bus_tag = t; bus_value = v; bus_exc = e;
    @(posedge clk); #0.5;
    bus_valid = 1'b0; bus_exc = 1'b0;
  endtask

  // Monitor: every write-back must match the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && rf_we) begin
      if (exp_q.size() == 0) begin
        nchk++; nerr++;
        $display("FAIL R5: unexpected commit addr %0h data %0h expected none", rf_addr, rf_data);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        chk({rf_addr, rf_data} == e, "R5 commit order/content", {rf_addr, rf_data}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(empty == 1 && full == 0, "R1 empty/full", {empty, full}, 2'b10);
    chk(rf_we == 0 && exc_flag == 0, "R1 outputs idle", {rf_we, exc_flag}, 0);
    chk(rd_hit_a == 0 && rd_hit_b == 0, "R1 no lookup hit", {rd_hit_a, rd_hit_b}, 0);

    // Three issues, two to the same address
    issue_one(5'd3, 32'h100, tg); chk(tg == 1, "R2 first tag", tg, 1);
    issue_one(5'd4, 32'h104, tg); chk(tg == 2, "R2 second tag", tg, 2);
    issue_one(5'd3, 32'h108, tg); chk(tg == 3, "R2 third tag", tg, 3);
    btail = 3;
    rd_addr_a = 5'd3; rd_addr_b = 5'd4;
    @(negedge clk);
    chk(rd_hit_a && rd_tag_a == 3 && !rd_ready_a, "R7 latest producer only", rd_tag_a, 3);
    chk(rd_hit_b && rd_tag_b == 2, "R8 port b independent", rd_tag_b, 2);

    // Youngest completes first: must not retire yet
    bus_put(5'd3, 32'h33, 1'b0);
    @(negedge clk);
    chk(rd_ready_a && rd_value_a == 32'h33, "R4 capture visible", rd_value_a, 32'h33);
    chk(rf_we == 0, "R5 younger waits", rf_we, 0);
    @(negedge clk);
    chk(rf_we == 0, "R5 younger still waits", rf_we, 0);

    expect_commit(5'd3, 32'h11);
    expect_commit(5'd4, 32'h22);
    expect_commit(5'd3, 32'h33);
    bus_put(5'd1, 32'h11, 1'b0);
    bus_put(5'd2, 32'h22, 1'b0);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all three retired", exp_q.size(), 0);
    chk(empty == 1, "R5 queue drained", empty, 1);
    chk(rd_hit_a == 0 && rd_hit_b == 0, "R10 no producer after retire", {rd_hit_a, rd_hit_b}, 0);

    // Fill across the wrap point
    for (int k = 0; k < DEPTH; k++) begin
      issue_one(AW'(k), PCW'(32'h400 + 4 * k), tg);
      chk(tg == TW'(btail + 1), "R2 tag sequence with wrap", tg, btail + 1);
      btail = (btail + 1) % DEPTH;
    end
    @(negedge clk);
    chk(full == 1, "R3 full after DEPTH issues", full, 1);
    iss_valid = 1'b1; iss_dest = 5'd31; iss_pc = 32'hBAD;
    #0.5 chk(iss_tag == TW'(btail + 1), "R3 tag before blocked issue", iss_tag, btail + 1);
    @(posedge clk); #0.5 iss_valid = 1'b0;
    @(negedge clk);
    chk(full == 1 && iss_tag == TW'(btail + 1), "R3 blocked issue ignored", iss_tag, btail + 1);
    rd_addr_a = 5'd31;
    #0.5 chk(rd_hit_a == 0, "R3 blocked issue not stored", rd_hit_a, 0);

    for (int k = 0; k < DEPTH; k++) expect_commit(AW'(k), DW'(k * 7 + 1));
    for (int k = 0; k < DEPTH; k++) bus_put(TW'((3 + k) % DEPTH + 1), DW'(k * 7 + 1), 1'b0);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R3 exactly DEPTH retirements", exp_q.size(), 0);
    chk(empty == 1 && full == 0, "R5 drained after fill", {empty, full}, 2'b10);
    repeat (3) begin
      @(negedge clk);
      chk(rf_we == 0, "R6 empty never retires", rf_we, 0);
    end

    // Exception at head (head and tail now at slot 3)
    issue_one(5'd9, 32'h200, tg);
    chk(tg == 4, "R2 tag after full lap", tg, 4);
    issue_one(5'd10, 32'h204, tg);
    bus_put(5'd5, 32'h55, 1'b0);
    bus_put(5'd4, 32'h0, 1'b1);
    @(negedge clk);
    chk(exc_flag == 0, "R9 flush not yet reported", exc_flag, 0);
    @(negedge clk);
    chk(exc_flag == 1 && exc_pc == 32'h200, "R9 exception pc", exc_pc, 32'h200);
    chk(empty == 1 && rf_we == 0, "R9 emptied without write", {empty, rf_we}, 2'b10);
    rd_addr_a = 5'd10; rd_addr_b = 5'd9;
    #0.5 chk(rd_hit_a == 0 && rd_hit_b == 0, "R9 lookups miss after flush", {rd_hit_a, rd_hit_b}, 0);
    @(negedge clk);
    chk(exc_flag == 0, "R9 single pulse", exc_flag, 0);

    // Issue during flush cycle is dropped (pointers restart at slot 0)
    issue_one(5'd12, 32'h300, tg);
    chk(tg == 1, "R2 tag after flush", tg, 1);
    bus_put(5'd1, 32'h0, 1'b1);
    issue_one(5'd13, 32'h304, tg);
    @(negedge clk);
    chk(exc_flag == 1 && exc_pc == 32'h300, "R11 second flush pc", exc_pc, 32'h300);
    rd_addr_a = 5'd13; rd_addr_b = 5'd12;
    #0.5 chk(rd_hit_a == 0 && rd_hit_b == 0, "R11 issue during flush discarded", {rd_hit_a, rd_hit_b}, 0);
    chk(empty == 1, "R11 queue empty", empty, 1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && rf_we == 0, "R6 idle after flush", rf_we, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule